// File: doc/BRIEF.md
# Software-Initiated Host CPU Reset Port

This block holds the two control bits of the host's fast reset port (I/O address 0x92) and turns a software request into a single, fixed-length reset pulse for the host processor. When the host writes the port with the reset bit going from 0 to 1, a pulse generator drives an internal active-low alternate reset line for a fixed number of clock cycles. That line is NANDed with the active-low reset pulse from the keyboard-command reset logic. The result is the active-high CPU reset output, so either source can reset the processor.

Re-triggering is guarded. A new pulse can only start after the reset bit has gone back to 0, either through system reset or through a port write with bit 0 clear. If software clears the bit and sets it again while a pulse is still running, no second pulse is produced. The second bit of the port holds the alternate A20 gate request. It is only stored, read back and exported.

The pulse generator is a three-state machine:
- `ST_IDLE`: the reset bit is 0 and no pulse is running. Transition *arm*: a write that sets bit 0 moves to `ST_PULSE`.
- `ST_PULSE`: the alternate reset line is driven low while a counter runs for `PULSE_CYCLES` cycles. Transition *done-clear*: when the count ends with the bit's next value 0, it moves to `ST_IDLE`. Transition *done-held*: when the count ends with the bit still 1, it moves to `ST_WAIT_CLR`.
- `ST_WAIT_CLR`: the pulse is over but the bit is still 1. Transition *release*: once the bit's next value is 0, it moves to `ST_IDLE`.

Top module: `host_sw_reset_port`

## Requirements
- R1: A port write with bit 0 = 1 while the stored reset bit is 0 and no pulse is running asserts `cpu_reset` from the cycle after the write edge for exactly `PULSE_CYCLES` cycles (default 16).
- R2: `cpu_reset` is high whenever `kbd_rst_n` is low or the alternate pulse is active. Otherwise it is low.
- R3: A write with bit 0 = 1 while the stored reset bit is already 1 produces no pulse.
- R4: A write with bit 0 = 0 clears the stored reset bit. A later write with bit 0 = 1 produces a new pulse, provided no pulse is running.
- R5: Clearing and then setting bit 0 while a pulse is running starts no second pulse and does not lengthen the running one. The bit stays 1 afterwards and must be cleared before the next pulse.
- R6: Every write stores bit 1 of the write data as the A20 request, which appears on `a20_req`.
- R7: `rd_data` returns the stored reset bit in bit 0 and the A20 request in bit 1. Bits 7:2 read as 0.
- R8: While `rst_n` is low, both stored bits are 0 and no alternate pulse is active. This holds even when reset arrives during a pulse, and the pulse ends at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| wr_en | input | 1 | Port write strobe, one cycle per write |
| wr_data | input | 8 | Port write data |
| rd_data | output | 8 | Port read data |
| kbd_rst_n | input | 1 | Active-low reset pulse from keyboard-command logic |
| a20_req | output | 1 | Stored alternate A20 request |
| cpu_reset | output | 1 | Active-high host CPU reset |

## Verification
Directed sequences cover the following cases:
- a clean 0-to-1 set, which shows the pulse length and start cycle;
- a repeated set while the bit is high, which tells the level from the edge;
- a clear-then-set inside a running pulse, which shows the re-trigger guard versus a naive edge detector;
- a clear followed by a set after the pulse ends, which shows the path back to the armed state.

The keyboard pulse is driven both alone and overlapping the alternate pulse to test the NAND merge. A reset in mid-pulse confirms the pulse is cut off.

Seeded random write and keyboard traffic then mixes all of these cases. Each cycle is compared against a bench model of the port bits and the remaining pulse length.

// File: rtl/swr_pkg.sv
package swr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_PULSE    = 2'd1,
        ST_WAIT_CLR = 2'd2
    } swr_state_e;

    localparam int RST_BIT = 0;
    localparam int A20_BIT = 1;
endpackage

// File: rtl/swr_ctl_reg.sv
module swr_ctl_reg
    import swr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              rst_bit_q,
    output logic              rst_bit_nxt,
    output logic              set_evt,
    output logic              a20_q,
    output logic [DATA_W-1:0] rd_data
);
    localparam int PAD_W = DATA_W - 2;

    always_comb begin
        rst_bit_nxt = wr_en ? wr_data[RST_BIT] : rst_bit_q;
        set_evt     = wr_en && wr_data[RST_BIT] && !rst_bit_q;
        rd_data     = {{PAD_W{1'b0}}, a20_q, rst_bit_q};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rst_bit_q <= 1'b0;
            a20_q     <= 1'b0;
        end else if (wr_en) begin
            rst_bit_q <= wr_data[RST_BIT];
            a20_q     <= wr_data[A20_BIT];
        end
    end

    // R4: a write with bit 0 clear leaves the reset bit at 0
    a_r4_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_data[RST_BIT]) |=> !rst_bit_q);

    // R6: the A20 request follows the written bit 1
    a_r6_a20_store: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (a20_q == $past(wr_data[A20_BIT])));
endmodule

// File: rtl/swr_pulse_fsm.sv
module swr_pulse_fsm
    import swr_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic rst_bit_q,
    input  logic rst_bit_nxt,
    output logic alt_rst_n
);
    localparam int CNT_W = (PULSE_CYCLES > 2) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PULSE_CYCLES - 1);

    swr_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic cnt_done;

    assign cnt_done = (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (set_evt) state_d = ST_PULSE;
            ST_PULSE:    if (cnt_done) state_d = rst_bit_nxt ? ST_WAIT_CLR : ST_IDLE;
            ST_WAIT_CLR: if (!rst_bit_nxt) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PULSE && !cnt_done) cnt_q <= cnt_q + 1'b1;
            else cnt_q <= '0;
        end
    end

    always_comb begin
        alt_rst_n = (state_q != ST_PULSE);
    end

    // R4: outside a pulse, the idle state means the bit has been released
    a_r4_idle_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !rst_bit_q);

    // R3: a held bit never restarts the pulse
    a_r3_no_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_CLR) |=> (state_q != ST_PULSE));

    // R1: a pulse only starts from a set event
    a_r1_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alt_rst_n) |-> $past(set_evt));

    // R5: a running pulse is never restarted mid-count
    a_r5_count_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PULSE && !cnt_done) |=> (state_q == ST_PULSE && cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/host_sw_reset_port.sv
module host_sw_reset_port #(
    parameter int DATA_W       = 8,
    parameter int PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              kbd_rst_n,
    output logic              a20_req,
    output logic              cpu_reset
);
    logic rst_bit_q, rst_bit_nxt, set_evt, alt_rst_n;

    swr_ctl_reg #(.DATA_W(DATA_W)) u_reg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rst_bit_q  (rst_bit_q),
        .rst_bit_nxt(rst_bit_nxt),
        .set_evt    (set_evt),
        .a20_q      (a20_req),
        .rd_data    (rd_data)
    );

    swr_pulse_fsm #(.PULSE_CYCLES(PULSE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_evt    (set_evt),
        .rst_bit_q  (rst_bit_q),
        .rst_bit_nxt(rst_bit_nxt),
        .alt_rst_n  (alt_rst_n)
    );

    // active-low sources merged by NAND into an active-high reset
    assign cpu_reset = ~(alt_rst_n & kbd_rst_n);

    // R2: the keyboard pulse alone is enough to reset the CPU
    a_r2_kbd_path: assert property (@(posedge clk) disable iff (!rst_n)
        !kbd_rst_n |-> cpu_reset);

    // R7: unused read bits stay zero
    a_r7_read_pad: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:2] == '0);

    // R8: no alternate pulse right after reset is released
    a_r8_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(rst_n) && kbd_rst_n) |-> !cpu_reset);
endmodule

// File: tb/tb_host_sw_reset_port.sv
`timescale 1ns/1ps
module tb_host_sw_reset_port;
    localparam int W = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       kbd_rst_n = 1'b1;
    logic       a20_req;
    logic       cpu_reset;

    int total = 0;
    int bad = 0;

    // bench model
    logic m_bit0 = 1'b0;
    logic m_bit1 = 1'b0;
    int   m_rem  = 0;

    always #4 clk = ~clk;

    host_sw_reset_port #(.DATA_W(8), .PULSE_CYCLES(W)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .kbd_rst_n(kbd_rst_n), .a20_req(a20_req),
        .cpu_reset(cpu_reset)
    );

    function automatic logic exp_reset(int rem, logic kbd_n);
        return (rem > 0) || !kbd_n;
    endfunction

    function automatic logic [7:0] exp_read(logic b1, logic b0);
        return {6'b0, b1, b0};
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_all(string req);
        chk(req, {7'b0, cpu_reset}, {7'b0, exp_reset(m_rem, kbd_rst_n)});
        chk("R7", rd_data, exp_read(m_bit1, m_bit0));
        chk("R6", {7'b0, a20_req}, {7'b0, m_bit1});
    endtask

    // called at a negedge: drive, take one edge, update model, back at negedge
    task automatic step(logic we, logic [7:0] d, logic kbd_n);
        logic trig;
        wr_en = we; wr_data = d; kbd_rst_n = kbd_n;
        @(posedge clk);
        trig = we && d[0] && !m_bit0 && (m_rem == 0);
        if (trig) m_rem = W;
        else if (m_rem > 0) m_rem--;
        if (we) begin m_bit0 = d[0]; m_bit1 = d[1]; end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n, string req);
        for (int i = 0; i < n; i++) begin
            step(1'b0, 8'h00, 1'b1);
            check_all(req);
        end
    endtask

    initial begin : watchdog
        #1000000;
        bad++; total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int hi;
        void'($urandom(32'd20240611));
        @(negedge clk); @(negedge clk);
        // R8: reset state
        check_all("R8");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8");

        // R1: clean set, count the pulse length
        step(1'b1, 8'h01, 1'b1);
        hi = 0;
        for (int i = 0; i < W + 4; i++) begin
            if (cpu_reset) hi++;
            check_all("R1");
            step(1'b0, 8'h00, 1'b1);
        end
        chk("R1", 8'(hi), 8'(W));

        // R3: setting again while bit is high gives no pulse
        step(1'b1, 8'h01, 1'b1);
        idle(W + 2, "R3");
        chk("R3", {7'b0, cpu_reset}, 8'h00);

        // R4: clear then set gives a new pulse
        step(1'b1, 8'h00, 1'b1);
        check_all("R4");
        step(1'b1, 8'h01, 1'b1);
        chk("R4", {7'b0, cpu_reset}, 8'h01);
        idle(4, "R4");

        // R5: clear-then-set inside the running pulse
        step(1'b1, 8'h00, 1'b1);
        step(1'b1, 8'h01, 1'b1);
        check_all("R5");
        idle(W + 2, "R5");
        chk("R5", {7'b0, cpu_reset}, 8'h00);
        chk("R5", rd_data, 8'h01);

        // R2: keyboard pulse alone and overlapping
        step(1'b1, 8'h00, 1'b1);
        step(1'b0, 8'h00, 1'b0);
        check_all("R2");
        chk("R2", {7'b0, cpu_reset}, 8'h01);
        step(1'b1, 8'h01, 1'b0);
        check_all("R2");
        step(1'b0, 8'h00, 1'b1);
        check_all("R2");

        // R6: A20 bit store and read back
        step(1'b1, 8'hFE, 1'b1);
        check_all("R6");
        chk("R6", {7'b0, a20_req}, 8'h01);
        idle(W + 2, "R6");

        // R8: reset mid-pulse ends it at once
        step(1'b1, 8'h00, 1'b1);
        step(1'b1, 8'h03, 1'b1);
        idle(3, "R1");
        #1;
        rst_n = 1'b0;
        m_bit0 = 1'b0; m_bit1 = 1'b0; m_rem = 0;
        #1;
        check_all("R8");
        chk("R8", {7'b0, cpu_reset}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R8");

        // random traffic
        for (int i = 0; i < 3000; i++) begin
            logic we, kn;
            logic [7:0] d;
            we = ($urandom % 6) == 0;
            d  = 8'($urandom);
            kn = ($urandom % 12) != 0;
            step(we, d, kn);
            check_all("R2");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule